// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

Two 8-bit up-counters, channel 0 and channel 1, sit behind one small register port that takes byte and halfword accesses. Each channel has a counter, two compare registers (A and B) and a control byte. The control byte picks the count source and also reports and clears the channel's two compare flags. Both channels can count a shared internal tick, which a divide-by-`DIV` prescaler makes from the clock. Channel 0 can instead count the overflows of channel 1. The pair then acts as one 16-bit counter, with channel 0 as the upper byte.

Address bits [2:1] select the register kind. Bit [0] selects the channel on a byte access. A halfword access covers both channels at once: channel 0 is in the upper byte and channel 1 in the lower byte, for both reads and writes. Read data is registered and comes back one cycle after the request, marked by `rd_valid`. The block accepts one request per cycle and never stalls, so the port has no ready signal and no back-pressure. Match and overflow events also appear as one-cycle pulses.

Top module: `dual_tmr8`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every counter, compare register, control field, flag, pulse output and `rd_valid` to zero.
- R2: A channel whose source code is 1 increments once per internal tick. The tick fires on every `DIV`-th clock edge after reset. The counter wraps from 0xFF to 0x00, and the wrap raises that channel's `ovf_pulse` bit for one cycle, together with the counter reading 0x00.
- R3: With source code 2, channel 0 increments once at each clock edge where channel 1 wraps, and ignores internal ticks.
- R4: Source code 0 and code 3 stop a channel, and code 2 also stops channel 1. A stopped counter holds its value but still takes writes.
- R5: Address map: `req_addr[2:1]` = 0 selects the counter, 1 compare A, 2 compare B and 3 control. On a byte access (`req_half`=0), `req_addr[0]` picks channel 0 (value 0) or channel 1 (value 1), and only that channel is read or written, using data bits [7:0].
- R6: A halfword read of any register kind returns channel 0's byte in bits 15:8 and channel 1's byte in bits 7:0.
- R7: A halfword write stores bits 15:8 into channel 0 and bits 7:0 into channel 1.
- R8: A read request made in one cycle gives `rd_valid` high with its data in the next cycle. Both bytes of a halfword read are sampled at the same edge, so a carry from channel 1 into channel 0 is never seen half-applied.
- R9: When a count event takes a channel's counter to a value equal to its compare A (or B) register, the channel's `cmpa_pulse` (or `cmpb_pulse`) bit is high for one cycle, together with the new count, and the matching sticky flag is set.
- R10: Control byte layout: bits [1:0] are the source code, bit 4 is flag A and bit 5 is flag B, and the other bits read as 0. Writing a 1 to bit 4 or bit 5 clears that flag. A match in the same cycle takes priority over the clear.
- R11: If a counter write and a count event for the same channel fall in the same cycle, the written value is stored, and that event causes neither an increment nor an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = halfword (both channels), 0 = byte |
| req_addr | input | 3 | [2:1] register kind, [0] channel for byte access |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 16 | Read data |
| ovf_pulse | output | 2 | Per-channel wrap pulse |
| cmpa_pulse | output | 2 | Per-channel compare-A match pulse |
| cmpb_pulse | output | 2 | Per-channel compare-B match pulse |

## Verification
Byte writes sweep all 256 values through each channel's counter while the channel is stopped. Each read-back is compared with the value written, and the other channel must keep its byte, which separates correct byte steering from halfword or mis-addressed writes. Halfword writes use asymmetric patterns, such as 0xA51C, so that a swapped byte order shows up. Channel 1 runs free across several wraps with its compare values near the wrap point, which separates the match, flag and overflow timing. A long cascade run with frequent halfword reads checks the 16-bit carry, and back-to-back counter writes during counting make writes collide with ticks.

// File: rtl/dual_tmr8_pkg.sv
package dual_tmr8_pkg;
  typedef enum logic [1:0] {
    SRC_STOP = 2'd0,
    SRC_TICK = 2'd1,
    SRC_CASC = 2'd2,
    SRC_HALT = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_CMPA = 2'd1,
    REG_CMPB = 2'd2,
    REG_CTRL = 2'd3
  } reg_e;

  localparam int FLAG_A_BIT = 4;
  localparam int FLAG_B_BIT = 5;
endpackage

// File: rtl/dual_tmr8_presc.sv
module dual_tmr8_presc #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign tick = !rst && (phase_q == LAST);
endmodule

// File: rtl/dual_tmr8_chan.sv
module dual_tmr8_chan
  import dual_tmr8_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter bit CASCADE_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             casc_evt,
  input  logic             wr_cnt,
  input  logic             wr_cmpa,
  input  logic             wr_cmpb,
  input  logic             wr_ctrl,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmpa,
  output logic [CNT_W-1:0] cmpb,
  output logic [1:0]       src,
  output logic             flag_a,
  output logic             flag_b,
  output logic             ovf_evt,
  output logic             ovf_p,
  output logic             match_a_p,
  output logic             match_b_p
);
  logic             src_evt;
  logic             evt;
  logic [CNT_W-1:0] nxt;
  logic             hit_a, hit_b, clr_a, clr_b;

  always_comb begin
    unique case (src)
      SRC_TICK: src_evt = tick;
      SRC_CASC: src_evt = CASCADE_OK ? casc_evt : 1'b0;
      default:  src_evt = 1'b0;
    endcase
  end

  assign evt     = src_evt && !wr_cnt;
  assign nxt     = cnt + 1'b1;
  assign ovf_evt = evt && (cnt == '1);
  assign hit_a   = evt && (nxt == cmpa);
  assign hit_b   = evt && (nxt == cmpb);
  assign clr_a   = wr_ctrl && wdata[FLAG_A_BIT];
  assign clr_b   = wr_ctrl && wdata[FLAG_B_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      cmpa      <= '0;
      cmpb      <= '0;
      src       <= SRC_STOP;
      flag_a    <= 1'b0;
      flag_b    <= 1'b0;
      ovf_p     <= 1'b0;
      match_a_p <= 1'b0;
      match_b_p <= 1'b0;
    end else begin
      if (wr_cnt) cnt <= wdata;
      else if (evt) cnt <= nxt;
      if (wr_cmpa) cmpa <= wdata;
      if (wr_cmpb) cmpb <= wdata;
      if (wr_ctrl) src <= wdata[1:0];
      flag_a    <= hit_a || (flag_a && !clr_a);
      flag_b    <= hit_b || (flag_b && !clr_b);
      ovf_p     <= ovf_evt;
      match_a_p <= hit_a;
      match_b_p <= hit_b;
    end
  end
endmodule

// File: rtl/dual_tmr8.sv
module dual_tmr8
  import dual_tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_half,
  input  logic [2:0]         req_addr,
  input  logic [2*CNT_W-1:0] req_wdata,
  output logic               rd_valid,
  output logic [2*CNT_W-1:0] rd_data,
  output logic [1:0]         ovf_pulse,
  output logic [1:0]         cmpa_pulse,
  output logic [1:0]         cmpb_pulse
);
  localparam int NCH = 2;
  localparam int DW  = NCH * CNT_W;

  reg_e             sel;
  logic             tick;
  logic             is_wr, is_rd;
  logic [CNT_W-1:0] cnt_q  [NCH];
  logic [CNT_W-1:0] cmpa_q [NCH];
  logic [CNT_W-1:0] cmpb_q [NCH];
  logic [1:0]       src_q  [NCH];
  logic [CNT_W-1:0] view   [NCH];
  logic [CNT_W-1:0] ch_wd  [NCH];
  logic [NCH-1:0]   fa_q, fb_q, ovf_evt, ch_sel;
  logic [NCH-1:0]   wr_cnt, wr_cmpa, wr_cmpb, wr_ctrl;

  assign sel   = reg_e'(req_addr[2:1]);
  assign is_wr = req_valid && req_write;
  assign is_rd = req_valid && !req_write;

  dual_tmr8_presc #(.DIV(DIV)) presc_i (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_sel[i]  = req_half || (req_addr[0] == 1'(i));
    assign ch_wd[i]   = req_half ? req_wdata[DW-1-i*CNT_W -: CNT_W]
                                 : req_wdata[CNT_W-1:0];
    assign wr_cnt[i]  = is_wr && ch_sel[i] && (sel == REG_CNT);
    assign wr_cmpa[i] = is_wr && ch_sel[i] && (sel == REG_CMPA);
    assign wr_cmpb[i] = is_wr && ch_sel[i] && (sel == REG_CMPB);
    assign wr_ctrl[i] = is_wr && ch_sel[i] && (sel == REG_CTRL);

    dual_tmr8_chan #(
      .CNT_W      (CNT_W),
      .CASCADE_OK (i == 0)
    ) chan_i (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .casc_evt  ((i == 0) ? ovf_evt[NCH-1] : 1'b0),
      .wr_cnt    (wr_cnt[i]),
      .wr_cmpa   (wr_cmpa[i]),
      .wr_cmpb   (wr_cmpb[i]),
      .wr_ctrl   (wr_ctrl[i]),
      .wdata     (ch_wd[i]),
      .cnt       (cnt_q[i]),
      .cmpa      (cmpa_q[i]),
      .cmpb      (cmpb_q[i]),
      .src       (src_q[i]),
      .flag_a    (fa_q[i]),
      .flag_b    (fb_q[i]),
      .ovf_evt   (ovf_evt[i]),
      .ovf_p     (ovf_pulse[i]),
      .match_a_p (cmpa_pulse[i]),
      .match_b_p (cmpb_pulse[i])
    );

    always_comb begin
      view[i] = '0;
      unique case (sel)
        REG_CNT:  view[i] = cnt_q[i];
        REG_CMPA: view[i] = cmpa_q[i];
        REG_CMPB: view[i] = cmpb_q[i];
        default: begin
          view[i][1:0]        = src_q[i];
          view[i][FLAG_A_BIT] = fa_q[i];
          view[i][FLAG_B_BIT] = fb_q[i];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= is_rd;
      if (is_rd) begin
        if (req_half) rd_data <= {view[0], view[1]};
        else rd_data <= {{CNT_W{1'b0}}, view[req_addr[0]]};
      end
    end
  end
endmodule

// File: rtl/dual_tmr8_chk.sv
module dual_tmr8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_half,
  input logic [2:0]       req_addr,
  input logic             wd_lo4,
  input logic             wd_hi4,
  input logic             rd_valid,
  input logic [1:0]       ovf_pulse,
  input logic [1:0]       cmpa_pulse,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [1:0]       src0,
  input logic [1:0]       src1,
  input logic             fa0,
  input logic             fa1,
  input logic             ovf_evt0,
  input logic             ovf_evt1,
  input logic             wr_cnt0,
  input logic             wr_cnt1
);
  logic ctrl_wr, clr_a1;
  assign ctrl_wr = req_valid && req_write && (req_addr[2:1] == 2'd3);
  assign clr_a1  = ctrl_wr && (req_half ? wd_lo4 : (req_addr[0] && wd_lo4));

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cnt0 == '0 && cnt1 == '0 && !fa0 && !fa1 && !rd_valid && ovf_pulse == 2'b00)); // R1
  AST_WRAP_CH1_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf_evt1 |=> (cnt1 == '0 && ovf_pulse[1])); // R2
  AST_WRAP_CH0_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf_evt0 |=> (cnt0 == '0 && ovf_pulse[0])); // R2
  AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (rst)
    (src0 == 2'd2 && ovf_evt1 && !wr_cnt0) |=> cnt0 == $past(cnt0) + 1'b1); // R3
  AST_CASCADE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (src0 == 2'd2 && !ovf_evt1 && !wr_cnt0) |=> $stable(cnt0)); // R3
  AST_STOP_HOLDS_CH0: assert property (@(posedge clk) disable iff (rst)
    ((src0 == 2'd0 || src0 == 2'd3) && !wr_cnt0) |=> $stable(cnt0)); // R4
  AST_STOP_HOLDS_CH1: assert property (@(posedge clk) disable iff (rst)
    (src1 != 2'd1 && !wr_cnt1) |=> $stable(cnt1)); // R4
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid); // R8
  AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid); // R8
  AST_MATCH_FLAG_CH0: assert property (@(posedge clk) disable iff (rst)
    cmpa_pulse[0] |-> fa0); // R9
  AST_MATCH_FLAG_CH1: assert property (@(posedge clk) disable iff (rst)
    cmpa_pulse[1] |-> fa1); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fa1 && !clr_a1) |=> fa1); // R10
endmodule

bind dual_tmr8 dual_tmr8_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_half   (req_half),
  .req_addr   (req_addr),
  .wd_lo4     (req_wdata[4]),
  .wd_hi4     (req_wdata[CNT_W+4]),
  .rd_valid   (rd_valid),
  .ovf_pulse  (ovf_pulse),
  .cmpa_pulse (cmpa_pulse),
  .cnt0       (cnt_q[0]),
  .cnt1       (cnt_q[1]),
  .src0       (src_q[0]),
  .src1       (src_q[1]),
  .fa0        (fa_q[0]),
  .fa1        (fa_q[1]),
  .ovf_evt0   (ovf_evt[0]),
  .ovf_evt1   (ovf_evt[1]),
  .wr_cnt0    (wr_cnt[0]),
  .wr_cnt1    (wr_cnt[1])
);

// File: tb/dual_tmr8_tb_top.sv
module dual_tmr8_tb_top;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_half = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [1:0]  ovf_pulse, cmpa_pulse, cmpb_pulse;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  dual_tmr8 #(.CNT_W(8), .DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_half(req_half), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ovf_pulse(ovf_pulse),
    .cmpa_pulse(cmpa_pulse), .cmpb_pulse(cmpb_pulse)
  );

  // Requirement-level model, advanced at each rising edge
  logic [7:0]  m_cnt [2], m_ca [2], m_cb [2];
  logic [1:0]  m_src [2];
  logic        m_fa [2], m_fb [2];
  logic [1:0]  m_ovf = '0, m_ma = '0, m_mb = '0;
  logic        m_rdv = 1'b0;
  logic [15:0] m_rd = '0;
  int          m_edges = 0;

  function automatic logic [7:0] mview(int ch, logic [1:0] r);
    case (r)
      2'd0: return m_cnt[ch];
      2'd1: return m_ca[ch];
      2'd2: return m_cb[ch];
      default: return {2'b00, m_fb[ch], m_fa[ch], 2'b00, m_src[ch]};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = '0; m_ca[c] = '0; m_cb[c] = '0; m_src[c] = '0;
        m_fa[c] = 1'b0; m_fb[c] = 1'b0;
      end
      m_ovf = '0; m_ma = '0; m_mb = '0; m_rdv = 1'b0; m_rd = '0; m_edges = 0;
    end else begin
      logic tick, ev1, ov1, ev;
      logic [7:0] n;
      logic [1:0] r;
      logic w [2];
      logic [7:0] wb [2];
      m_edges++;
      tick = (m_edges % DIV) == 0;
      r = req_addr[2:1];
      m_rdv = req_valid && !req_write;
      if (m_rdv) m_rd = req_half ? {mview(0, r), mview(1, r)} : {8'h00, mview(int'(req_addr[0]), r)};
      for (int c = 0; c < 2; c++) begin
        w[c]  = req_valid && req_write && (req_half || int'(req_addr[0]) == c);
        wb[c] = req_half ? (c == 0 ? req_wdata[15:8] : req_wdata[7:0]) : req_wdata[7:0];
      end
      ev1 = !(w[1] && r == 2'd0) && m_src[1] == 2'd1 && tick;
      ov1 = ev1 && m_cnt[1] == 8'hFF;
      for (int c = 0; c < 2; c++) begin
        ev = (c == 1) ? ev1 : (!(w[0] && r == 2'd0) &&
             ((m_src[0] == 2'd1 && tick) || (m_src[0] == 2'd2 && ov1)));
        n = m_cnt[c] + 8'd1;
        m_ovf[c] = ev && m_cnt[c] == 8'hFF;
        m_ma[c]  = ev && n == m_ca[c];
        m_mb[c]  = ev && n == m_cb[c];
        m_fa[c]  = m_ma[c] || (m_fa[c] && !(w[c] && r == 2'd3 && wb[c][4]));
        m_fb[c]  = m_mb[c] || (m_fb[c] && !(w[c] && r == 2'd3 && wb[c][5]));
        if (ev) m_cnt[c] = n;
        if (w[c]) begin
          case (r)
            2'd0: m_cnt[c] = wb[c];
            2'd1: m_ca[c] = wb[c];
            2'd2: m_cb[c] = wb[c];
            default: m_src[c] = wb[c][1:0];
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (m_rdv || rd_valid) begin
        checks++;
        if (rd_valid !== m_rdv || rd_data !== m_rd) begin
          errors++;
          $display("FAIL %s/R8 read: got v=%b d=%h expected v=%b d=%h", cur_req, rd_valid, rd_data, m_rdv, m_rd);
        end
      end
      if ({ovf_pulse, cmpa_pulse, cmpb_pulse} != 6'd0 || {m_ovf, m_ma, m_mb} != 6'd0) begin
        checks++;
        if ({ovf_pulse, cmpa_pulse, cmpb_pulse} !== {m_ovf, m_ma, m_mb}) begin
          errors++;
          $display("FAIL %s/R9 pulses ovf/a/b: got %b expected %b", cur_req,
                   {ovf_pulse, cmpa_pulse, cmpb_pulse}, {m_ovf, m_ma, m_mb});
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic half, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_half = half; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic half, input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_half = half; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d, prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: everything zero after reset
    cur_req = "R1";
    for (int k = 0; k < 4; k++) begin
      rd(1'b1, 3'(k * 2), d);
      chk("R1 reset halfword", d, 16'h0000);
    end

    // R5 / R4: exhaustive byte sweep on stopped channels
    cur_req = "R5";
    for (int ch = 0; ch < 2; ch++) begin
      for (int v = 0; v < 256; v++) begin
        wr(1'b0, 3'(ch), 16'(v) | 16'hA500);
        rd(1'b0, 3'(ch), d);
        chk("R5 byte counter", d, 16'(v));
        rd(1'b0, 3'(1 - ch), d);
        chk("R5 other channel untouched", d, (ch == 1) ? 16'h00FF : 16'h0000);
      end
    end
    cur_req = "R4";
    idle(20);
    rd(1'b1, 3'd0, d);
    chk("R4 stopped counters hold", d, 16'hFFFF);

    // R6 / R7: halfword split and merge for every register kind
    cur_req = "R7";
    for (int k = 0; k < 3; k++) begin
      wr(1'b1, 3'(k * 2), 16'hA51C ^ 16'(k * 16'h1111));
      rd(1'b0, 3'(k * 2), d);
      chk("R7 halfword write high byte to ch0", d, {8'h00, 8'hA5 ^ 8'(k * 8'h11)});
      rd(1'b0, 3'(k * 2 + 1), d);
      chk("R7 halfword write low byte to ch1", d, {8'h00, 8'h1C ^ 8'(k * 8'h11)});
      rd(1'b1, 3'(k * 2), d);
      chk("R6 halfword merge", d, 16'hA51C ^ 16'(k * 16'h1111));
    end

    // R10 / R4: control codes 3 and 2-on-ch1 stop
    cur_req = "R10";
    wr(1'b1, 3'd6, 16'h03C2);
    rd(1'b1, 3'd6, d);
    chk("R10 control layout (only [1:0] stored)", d, 16'h0302);
    rd(1'b1, 3'd0, prev);
    idle(30);
    rd(1'b1, 3'd0, d);
    chk("R4 codes 3 and 2-on-ch1 hold", d, prev);

    // R2 / R9 / R10: channel 1 free running across wraps
    cur_req = "R9";
    wr(1'b0, 3'd1, 16'h00F8);
    wr(1'b0, 3'd3, 16'h00FE);
    wr(1'b0, 3'd5, 16'h0002);
    wr(1'b0, 3'd7, 16'h0001);
    idle(DIV * 600);
    wr(1'b0, 3'd7, 16'h0000);
    rd(1'b0, 3'd7, d);
    chk("R9 both flags set after matches", d, 16'h0030);
    wr(1'b0, 3'd7, 16'h0010);
    rd(1'b0, 3'd7, d);
    chk("R10 flag A cleared, B kept", d, 16'h0020);
    wr(1'b0, 3'd7, 16'h0020);
    rd(1'b0, 3'd7, d);
    chk("R10 flag B cleared", d, 16'h0000);

    // R3 / R8: cascade, halfword reads racing the carry
    cur_req = "R3";
    wr(1'b1, 3'd0, 16'h00FA);
    wr(1'b1, 3'd6, 16'h0201);
    prev = 16'h00FA;
    for (int k = 0; k < 120; k++) begin
      idle(k % 7);
      rd(1'b1, 3'd0, d);
      checks++;
      if (d < prev) begin
        errors++;
        $display("FAIL R3 16-bit count went back: got %h expected >= %h", d, prev);
      end
      prev = d;
    end
    wr(1'b1, 3'd6, 16'h0000);
    rd(1'b1, 3'd0, d);
    chk("R3 cascade value vs model", d, {m_cnt[0], m_cnt[1]});
    chk("R3 upper byte advanced", {8'h00, d[15:8]}, 16'h0001 + 16'(d[15:8] - 8'd1));
    checks++;
    if (d[15:8] == 8'h00) begin
      errors++;
      $display("FAIL R3 upper byte never advanced: got %h expected nonzero", d[15:8]);
    end

    // R11: counter writes colliding with ticks
    cur_req = "R11";
    wr(1'b0, 3'd7, 16'h0001);
    for (int k = 0; k < 4 * DIV; k++) begin
      wr(1'b0, 3'd1, 16'(8'hFF));
      rd(1'b0, 3'd1, d);
    end
    wr(1'b0, 3'd7, 16'h0000);
    rd(1'b0, 3'd1, d);
    chk("R11 write vs tick", d, {8'h00, m_cnt[1]});

    idle(5);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule